// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit

This block multiplies two signed operands on every valid cycle and folds the product into a wide signed accumulator. Two per-operation controls choose what happens to the running total. The load control replaces the total with the bare product, which starts a new sum without spending a cycle on clearing. The subtract control picks whether the product is added to the total or taken away from it. Both controls travel down the pipeline beside their own operands, so an operand pair and its controls always act together.

The accumulator value goes through a rounding and saturation stage before it reaches the registered output. Rounding is half-up at a bit position chosen at run time, and saturation clamps to the limits of the output width. If an add or subtract wraps the accumulator, a flag is set and stays set until reset. An optional operand register and an optional product register can be included at build time to raise the clock rate. The valid strobe is delayed to match the data.

Top module: `mac_unit`

## Requirements
- R1: A valid cycle with the load control at 1 sets the accumulator to the signed product of the two operands, sign-extended, and discards the previous total.
- R2: A valid cycle with load at 0 and subtract at 0 sets the accumulator to the previous total plus the product.
- R3: A valid cycle with load at 0 and subtract at 1 sets the accumulator to the previous total minus the product.
- R4: A cycle with the valid input at 0 leaves the accumulator unchanged and produces no output strobe, whatever the operand and control inputs carry.
- R5: Every valid input produces exactly one output strobe, IN_REG + PIPE_REG + 2 clock edges later, with results in issue order.
- R6: With rounding position s, the output is floor((acc + 2^(s-1)) / 2^s) for s > 0 and acc unchanged for s = 0. The position input is held steady while results are in flight.
- R7: A rounded value above 2^(OUT_W-1)-1 is output as 2^(OUT_W-1)-1, and one below -2^(OUT_W-1) is output as -2^(OUT_W-1).
- R8: When an add or subtract result does not fit in ACC_W signed bits, the accumulator keeps the wrapped low bits and the overflow flag goes to 1 for that result. The flag then stays at 1 for all later results until reset.
- R9: While the active-low reset is low, the registers clear: out_valid, out_data and acc_ovf read 0 and the accumulator total is 0.
- R10: The load and subtract controls are taken from the same valid cycle as their operands, even when they change on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| in_a | input | A_W | Signed operand A |
| in_b | input | B_W | Signed operand B |
| in_load | input | 1 | 1: load the product, 0: accumulate |
| in_sub | input | 1 | When accumulating, 1 subtracts and 0 adds |
| round_pos | input | SHIFT_W | Number of low bits removed with half-up rounding |
| out_valid | output | 1 | Result strobe |
| out_data | output | OUT_W | Rounded, saturated accumulator value |
| acc_ovf | output | 1 | Sticky accumulator wrap flag, aligned with out_data |

## Verification
A result is due IN_REG + PIPE_REG + 2 edges after its operands are driven. The bench runs the fully registered build (4 edges) and the build with both optional registers removed (2 edges) side by side on the same stimulus. Inputs are driven and outputs sampled on the falling edge. Each expected result carries the cycle in which it was issued, and when a strobe is seen the bench checks that the elapsed cycle count equals that build's latency, then compares the data and the flag. A strobe with no pending expectation and an expectation left without a strobe after draining both count as failures.

// File: rtl/mac_pkg.sv
// Package: shared types for the multiply-accumulate unit.
// Assumes: the consumer decodes one accumulator operation per cycle.
package mac_pkg;

    // Operation applied to the accumulator in a given cycle.
    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_LOAD = 2'd1,
        ACC_ADD  = 2'd2,
        ACC_SUB  = 2'd3
    } acc_op_e;

    // Maps the valid strobe and the two controls to one operation.
    function automatic acc_op_e mac_decode(input logic vld, input logic ld, input logic sb);
        if (!vld)
            return ACC_HOLD;
        else if (ld)
            return ACC_LOAD;
        else if (sb)
            return ACC_SUB;
        else
            return ACC_ADD;
    endfunction

endpackage

// File: rtl/mac_pipe_reg.sv
// Module: one pipeline stage that carries a valid strobe and a data bundle.
// Assumes: the data only matters while its valid bit is set. The data is
// still cleared on reset so that the pipeline starts from a known state.
module mac_pipe_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         d_v,
    input  logic [W-1:0] d,
    output logic         q_v,
    output logic [W-1:0] q
);

    // Register the strobe and the bundle together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_v <= 1'b0;
            q   <= '0;
        end else begin
            q_v <= d_v;
            q   <= d;
        end
    end

endmodule

// File: rtl/mac_accum.sv
// Module: the accumulator register with load, add and subtract feedback, and
// a sticky wrap flag.
// Assumes: ACC_W + 1 > P_W. The product arrives with its own controls
// already aligned to it.
module mac_accum
    import mac_pkg::*;
#(
    parameter int P_W   = 36,
    parameter int ACC_W = 44
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_v,
    input  logic [P_W-1:0]   prod,
    input  logic             ld,
    input  logic             sb,
    output logic             acc_v,
    output logic [ACC_W-1:0] acc,
    output logic             ovf
);

    localparam int EXT_W = ACC_W + 1;

    acc_op_e          op_c;
    logic [EXT_W-1:0] p_ext_c;
    logic [EXT_W-1:0] a_ext_c;
    logic [EXT_W-1:0] nxt_c;
    logic             wrap_c;

    // Decode the operation and form the result one bit wider than the total.
    always_comb begin
        op_c    = mac_decode(in_v, ld, sb);
        p_ext_c = {{(EXT_W-P_W){prod[P_W-1]}}, prod};
        a_ext_c = {acc[ACC_W-1], acc};
        nxt_c   = (op_c == ACC_SUB) ? (a_ext_c - p_ext_c) : (a_ext_c + p_ext_c);
        wrap_c  = nxt_c[EXT_W-1] ^ nxt_c[EXT_W-2];
    end

    // Update the running total and the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            ovf   <= 1'b0;
            acc_v <= 1'b0;
        end else begin
            acc_v <= in_v;
            case (op_c)
                ACC_LOAD: acc <= p_ext_c[ACC_W-1:0];
                ACC_ADD, ACC_SUB: begin
                    acc <= nxt_c[ACC_W-1:0];
                    ovf <= ovf | wrap_c;
                end
                default: acc <= acc;
            endcase
        end
    end

endmodule

// File: rtl/mac_round_sat.sv
// Module: half-up rounding at a run-time bit position, clamping to the output
// width, and the output register.
// Assumes: 2**SHIFT_W <= ACC_W and round_pos stays steady while results are
// in flight.
module mac_round_sat #(
    parameter int ACC_W   = 44,
    parameter int OUT_W   = 18,
    parameter int SHIFT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_v,
    input  logic [ACC_W-1:0]   acc,
    input  logic               ovf,
    input  logic [SHIFT_W-1:0] round_pos,
    output logic               out_v,
    output logic [OUT_W-1:0]   out_d,
    output logic               out_ovf
);

    localparam int          EXT_W   = ACC_W + 1;
    localparam logic [OUT_W-1:0] SAT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] SAT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    logic signed [EXT_W-1:0] ext_c;
    logic signed [EXT_W-1:0] half_c;
    logic signed [EXT_W-1:0] sum_c;
    logic signed [EXT_W-1:0] shr_c;
    logic [EXT_W-OUT_W:0]    top_c;
    logic                    fits_c;
    logic [OUT_W-1:0]        sat_c;

    // Add half of one output step, shift arithmetically, then clamp.
    always_comb begin
        ext_c  = {acc[ACC_W-1], acc};
        half_c = (round_pos == '0) ? '0 : (EXT_W'(1) << (round_pos - SHIFT_W'(1)));
        sum_c  = ext_c + half_c;
        shr_c  = sum_c >>> round_pos;
        top_c  = shr_c[EXT_W-1:OUT_W-1];
        fits_c = (&top_c) | ~(|top_c);
        sat_c  = fits_c ? shr_c[OUT_W-1:0] : (shr_c[EXT_W-1] ? SAT_MIN : SAT_MAX);
    end

    // Register the result, its strobe and the flag aligned with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v   <= 1'b0;
            out_d   <= '0;
            out_ovf <= 1'b0;
        end else begin
            out_v   <= in_v;
            out_ovf <= ovf;
            if (in_v)
                out_d <= sat_c;
        end
    end

endmodule

// File: rtl/mac_unit.sv
// Module: top of the signed multiply-accumulate unit. It contains the optional
// operand register, the multiplier, the optional product register, the
// accumulator and the round/saturate output stage.
// Assumes: IN_REG and PIPE_REG are 0 or 1, ACC_W > A_W + B_W, and
// 2**SHIFT_W <= ACC_W.
module mac_unit #(
    parameter int A_W      = 18,
    parameter int B_W      = 18,
    parameter int ACC_W    = 44,
    parameter int OUT_W    = 18,
    parameter int SHIFT_W  = 5,
    parameter int IN_REG   = 1,
    parameter int PIPE_REG = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [A_W-1:0]     in_a,
    input  logic [B_W-1:0]     in_b,
    input  logic               in_load,
    input  logic               in_sub,
    input  logic [SHIFT_W-1:0] round_pos,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_data,
    output logic               acc_ovf
);

    localparam int P_W  = A_W + B_W;
    localparam int S1_W = A_W + B_W + 2;
    localparam int S2_W = P_W + 2;
    localparam int LAT  = IN_REG + PIPE_REG + 2;

    logic                    op_v;
    logic [S1_W-1:0]         op_bus;
    logic [A_W-1:0]          op_a;
    logic [B_W-1:0]          op_b;
    logic                    op_load;
    logic                    op_sub;
    logic signed [P_W-1:0]   mul_c;
    logic                    pr_v;
    logic [S2_W-1:0]         pr_bus;
    logic [P_W-1:0]          pr_prod;
    logic                    pr_load;
    logic                    pr_sub;
    logic                    ac_v;
    logic [ACC_W-1:0]        ac_val;
    logic                    ac_ovf;

    // Operand stage: registered or passed straight through.
    if (IN_REG != 0) begin : g_in_reg
        mac_pipe_reg #(.W(S1_W)) u_in_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .d_v   (in_valid),
            .d     ({in_load, in_sub, in_a, in_b}),
            .q_v   (op_v),
            .q     (op_bus)
        );
    end else begin : g_in_wire
        assign op_v   = in_valid;
        assign op_bus = {in_load, in_sub, in_a, in_b};
    end

    assign {op_load, op_sub, op_a, op_b} = op_bus;

    // Signed product of the aligned operands.
    assign mul_c = $signed(op_a) * $signed(op_b);

    // Product stage: registered or passed straight through.
    if (PIPE_REG != 0) begin : g_pipe_reg
        mac_pipe_reg #(.W(S2_W)) u_pipe_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .d_v   (op_v),
            .d     ({op_load, op_sub, mul_c}),
            .q_v   (pr_v),
            .q     (pr_bus)
        );
    end else begin : g_pipe_wire
        assign pr_v   = op_v;
        assign pr_bus = {op_load, op_sub, mul_c};
    end

    assign {pr_load, pr_sub, pr_prod} = pr_bus;

    mac_accum #(
        .P_W   (P_W),
        .ACC_W (ACC_W)
    ) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .in_v  (pr_v),
        .prod  (pr_prod),
        .ld    (pr_load),
        .sb    (pr_sub),
        .acc_v (ac_v),
        .acc   (ac_val),
        .ovf   (ac_ovf)
    );

    mac_round_sat #(
        .ACC_W   (ACC_W),
        .OUT_W   (OUT_W),
        .SHIFT_W (SHIFT_W)
    ) u_round_sat (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_v      (ac_v),
        .acc       (ac_val),
        .ovf       (ac_ovf),
        .round_pos (round_pos),
        .out_v     (out_valid),
        .out_d     (out_data),
        .out_ovf   (acc_ovf)
    );

endmodule

// File: rtl/mac_unit_checker.sv
// Module: assertions for mac_unit. The bind statement below attaches it to
// every instance of the top.
// Assumes: LAT is small (at most 4), so a fixed $past depth is cheap.
module mac_unit_checker #(
    parameter int LAT   = 4,
    parameter int ACC_W = 44,
    parameter int P_W   = 36
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic             acc_ovf,
    input logic             acc_en,
    input logic             acc_load,
    input logic [P_W-1:0]   acc_prod,
    input logic [ACC_W-1:0] acc_q
);

    int since_rst;

    // Count the edges since reset, up to LAT, so that $past stays inside them.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= 0;
        else if (since_rst < LAT)
            since_rst <= since_rst + 1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= LAT) |-> (out_valid == $past(in_valid, LAT))); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ovf |=> acc_ovf); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> $stable(acc_q)); // R4

    AST_LOAD_TAKES_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_load) |=> ($signed(acc_q) == $signed($past(acc_prod)))); // R1

endmodule

bind mac_unit mac_unit_checker #(
    .LAT   (LAT),
    .ACC_W (ACC_W),
    .P_W   (P_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .acc_ovf   (acc_ovf),
    .acc_en    (pr_v),
    .acc_load  (pr_load),
    .acc_prod  (pr_prod),
    .acc_q     (ac_val)
);

// File: tb/mac_unit_tb_top.sv
// Bench: runs a fully registered build and a build with both optional
// registers removed on the same stimulus. It sweeps a small 4x4-bit
// configuration exhaustively and compares each result against an arithmetic
// model.
module mac_unit_tb_top;

    localparam int AW  = 4;
    localparam int BW  = 4;
    localparam int ACC = 12;
    localparam int OW  = 6;
    localparam int SW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [AW-1:0] in_a = '0;
    logic [BW-1:0] in_b = '0;
    logic          in_load = 1'b0;
    logic          in_sub = 1'b0;
    logic [SW-1:0] round_pos = '0;
    logic          ov_f, ov_m, of_f, of_m;
    logic [OW-1:0] od_f, od_m;

    int     checks = 0;
    int     errors = 0;
    int     cycle = 0;
    bit     done = 1'b0;
    string  tag = "R9";
    longint m_acc = 0;
    bit     m_ovf = 1'b0;
    int     exp_data[$];
    bit     exp_ovf[$];
    int     exp_cyc[$];
    int     rd_f = 0;
    int     rd_m = 0;

    always #2.5 clk = ~clk;

    mac_unit #(.A_W(AW), .B_W(BW), .ACC_W(ACC), .OUT_W(OW), .SHIFT_W(SW),
               .IN_REG(1), .PIPE_REG(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_load(in_load), .in_sub(in_sub), .round_pos(round_pos),
        .out_valid(ov_f), .out_data(od_f), .acc_ovf(of_f));

    mac_unit #(.A_W(AW), .B_W(BW), .ACC_W(ACC), .OUT_W(OW), .SHIFT_W(SW),
               .IN_REG(0), .PIPE_REG(0)) dut_min_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_load(in_load), .in_sub(in_sub), .round_pos(round_pos),
        .out_valid(ov_m), .out_data(od_m), .acc_ovf(of_m));

    // Expected output: half-up rounding (R6), then clamping (R7).
    function automatic int round_sat(input longint v, input int s);
        longint r = v;
        if (s > 0) r = r + (longint'(1) <<< (s - 1));
        r = r >>> s;
        if (r > (2 ** (OW - 1)) - 1) r = (2 ** (OW - 1)) - 1;
        if (r < -(2 ** (OW - 1))) r = -(2 ** (OW - 1));
        return int'(r);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Check one build's output against the next pending expectation.
    task automatic check_port(input string who, input int lat, input logic v,
                              input logic [OW-1:0] d, input logic f, inout int rd);
        if (v) begin
            if (rd >= exp_data.size()) begin
                check(1'b0, "R4", {who, " strobe with nothing issued"}, 1, 0);
            end else begin
                check(cycle - exp_cyc[rd] == lat, "R5", {who, " latency"},
                      cycle - exp_cyc[rd], lat);
                check(int'($signed(d)) == exp_data[rd], tag, {who, " data"},
                      int'($signed(d)), exp_data[rd]);
                check(f == exp_ovf[rd], tag, {who, " overflow flag"},
                      int'(f), int'(exp_ovf[rd]));
                rd++;
            end
        end
    endtask

    // One cycle: sample both builds, then drive the next input and model it.
    task automatic issue(input bit v, input int a, input int b, input bit ld, input bit sb);
        longint p, full, w;
        @(negedge clk);
        cycle++;
        check_port("full", 4, ov_f, od_f, of_f, rd_f);
        check_port("min", 2, ov_m, od_m, of_m, rd_m);
        in_valid = v;
        in_a     = AW'(a);
        in_b     = BW'(b);
        in_load  = ld;
        in_sub   = sb;
        if (v) begin
            p = longint'(a) * longint'(b);
            if (ld) begin
                m_acc = p;                              // R1
            end else begin
                full = sb ? (m_acc - p) : (m_acc + p);  // R2, R3
                w = full & ((longint'(1) <<< ACC) - 1);
                if (w >= (longint'(1) <<< (ACC - 1))) w = w - (longint'(1) <<< ACC);
                if (w != full) m_ovf = 1'b1;            // R8
                m_acc = w;
            end
            exp_data.push_back(round_sat(m_acc, int'(round_pos)));
            exp_ovf.push_back(m_ovf);
            exp_cyc.push_back(cycle);
        end
    endtask

    // Idle cycles, then confirm every issued operation has come out (R5).
    task automatic drain();
        repeat (6) issue(1'b0, 0, 0, 1'b0, 1'b0);
        check(rd_f == exp_data.size(), "R5", "full results missing", rd_f, exp_data.size());
        check(rd_m == exp_data.size(), "R5", "min results missing", rd_m, exp_data.size());
    endtask

    // Hold reset for three cycles, check the cleared outputs (R9), then release.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(ov_f == 1'b0 && ov_m == 1'b0, "R9", "valid in reset", int'(ov_f) + int'(ov_m), 0);
        check(od_f == '0 && od_m == '0, "R9", "data in reset",
              int'($signed(od_f)) + int'($signed(od_m)), 0);
        check(of_f == 1'b0 && of_m == 1'b0, "R9", "flag in reset", int'(of_f) + int'(of_m), 0);
        rst_n = 1'b1;
        m_acc = 0;
        m_ovf = 1'b0;
        rd_f = exp_data.size();
        rd_m = exp_data.size();
    endtask

    initial begin
        do_reset();

        // R1 R7 R10: every operand pair loaded back to back, no rounding.
        tag = "R1 R7 R10";
        round_pos = '0;
        for (int a = -8; a < 8; a++)
            for (int b = -8; b < 8; b++)
                issue(1'b1, a, b, 1'b1, 1'b0);
        drain();

        // R2 R3 R4 R6 R10: mixed add/subtract with bubbles, every rounding position.
        tag = "R2 R3 R4 R6 R10";
        for (int s = 0; s < 8; s++) begin
            round_pos = SW'(s);
            issue(1'b1, 7, 7, 1'b1, 1'b0);
            for (int k = 0; k < 48; k++) begin
                if (k % 7 == 3)
                    issue(1'b0, -8, -8, 1'b1, 1'b1);   // R4 garbage on an idle cycle
                else
                    issue(1'b1, ((k * 5 + s) % 16) - 8, ((k * 3 + 7) % 16) - 8,
                          (k % 16) == 15, (k % 3) == 1);
            end
            drain();
        end

        // R8: repeated adds of 64 wrap the 12-bit total; the flag stays set after a load.
        tag = "R8";
        round_pos = SW'(7);
        issue(1'b1, -8, -8, 1'b1, 1'b0);
        for (int k = 0; k < 40; k++) issue(1'b1, -8, -8, 1'b0, 1'b0);
        issue(1'b1, 1, 1, 1'b1, 1'b0);
        issue(1'b1, 3, -2, 1'b0, 1'b1);
        drain();

        // R9: reset clears the flag and the total, then operation resumes.
        do_reset();
        tag = "R9 R2";
        round_pos = '0;
        issue(1'b1, 0, 0, 1'b0, 1'b0);
        issue(1'b1, 2, 3, 1'b0, 1'b0);
        issue(1'b1, -5, 1, 1'b0, 1'b1);
        drain();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycle, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule